// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block sits between instruction fetch and a single-issue datapath. It takes the 6-bit major opcode and the 6-bit function field of an instruction word and produces every control line the datapath needs: register-destination select, second-operand select, write-back source select, register write enable, memory read and write enables, a branch flag, a next-PC select and a 4-bit ALU operation code.

Decoding is split into two levels. The first level looks only at the opcode. It produces the single-bit controls and a 2-bit operation class. The second level turns that class into the ALU code, and it reads the function field only when the class marks a register-register instruction. The next-PC select is the branch flag ANDed with the ALU zero flag. All outputs are registered. A word presented on one rising edge appears on the outputs after that edge, and a synchronous active-high reset clears them.

Port vector used below: {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, pc_sel, alu_ctl[3:0]}.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: While rst is high at a rising edge, every output becomes 0 after that edge.
- R2: With rst low, the outputs after a rising edge reflect the opcode, funct and zero inputs sampled at that edge. Between edges the outputs hold.
- R3: Opcode 0x00 (register-register) gives reg_dst=1, reg_wr=1, alu_src=0, mem_to_reg=0, mem_rd=0, mem_wr=0, branch=0, pc_sel=0.
- R4: For opcode 0x00, funct maps to alu_ctl as follows: 0x24→0000 (and), 0x25→0001 (or), 0x20→0010 (add), 0x22→0110 (subtract), 0x2A→0111 (set-less-than). alu_ctl[2] equals funct[1] for these codes.
- R5: Opcode 0x23 (load) gives alu_src=1, mem_rd=1, mem_to_reg=1, reg_wr=1, reg_dst=0, mem_wr=0, branch=0, alu_ctl=0010. funct is ignored.
- R6: Opcode 0x2B (store) gives alu_src=1, mem_wr=1, reg_wr=0, mem_rd=0, reg_dst=0, mem_to_reg=0, branch=0, alu_ctl=0010. funct is ignored.
- R7: Opcode 0x04 (branch-if-equal) gives branch=1, alu_ctl=0110, and reg_wr, mem_rd, mem_wr, alu_src, reg_dst and mem_to_reg all 0. funct is ignored.
- R8: pc_sel is 1 only when the sampled opcode is 0x04 and zero was 1.
- R9: Any other opcode drives reg_wr, mem_rd, mem_wr, branch and pc_sel to 0, with alu_ctl=0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Major opcode of the instruction word |
| funct | input | 6 | Function field of the instruction word |
| zero | input | 1 | ALU result-is-zero flag |
| reg_dst | output | 1 | 1: destination from rd field, 0: from rt field |
| alu_src | output | 1 | 1: second ALU operand is the sign-extended immediate |
| mem_to_reg | output | 1 | 1: write-back data comes from memory |
| reg_wr | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| branch | output | 1 | Instruction is a conditional branch |
| pc_sel | output | 1 | 1: next PC is the branch target |
| alu_ctl | output | 4 | ALU operation code |

## Verification
A wrong operation class in the first level shows up one edge later as a wrong alu_ctl, even when the enables look correct. So every opcode is checked on the full output vector and not only on its enables. A function field that leaks into a non-register opcode only shows when that opcode is paired with an arithmetic funct, so loads, stores and branches are driven with varied funct values. A register stage that fails to hold or to clear shows within one edge as stale values, so outputs are also checked just before each edge and during reset.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;
  localparam int AC_W = 4;

  localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  localparam logic [AC_W-1:0] ALU_AND = 4'b0000;
  localparam logic [AC_W-1:0] ALU_OR  = 4'b0001;
  localparam logic [AC_W-1:0] ALU_ADD = 4'b0010;
  localparam logic [AC_W-1:0] ALU_SUB = 4'b0110;
  localparam logic [AC_W-1:0] ALU_SLT = 4'b0111;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_REG = 2'b10
  } op_class_e;

  typedef struct packed {
    logic      reg_dst;
    logic      alu_src;
    logic      mem_to_reg;
    logic      reg_wr;
    logic      mem_rd;
    logic      mem_wr;
    logic      branch;
    op_class_e cls;
  } main_ctl_t;

endpackage

// File: rtl/ctl_main_level.sv
module ctl_main_level
  import ctl_dec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output main_ctl_t       ctl
);

  always_comb begin
    ctl = '{default: '0, cls: CLS_MEM};
    unique case (opcode)
      OPC_REG: begin
        ctl.reg_dst = 1'b1;
        ctl.reg_wr  = 1'b1;
        ctl.cls     = CLS_REG;
      end
      OPC_LOAD: begin
        ctl.alu_src    = 1'b1;
        ctl.mem_rd     = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_wr     = 1'b1;
      end
      OPC_STORE: begin
        ctl.alu_src = 1'b1;
        ctl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.cls    = CLS_BR;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ctl_alu_level.sv
module ctl_alu_level
  import ctl_dec_pkg::*;
(
  input  op_class_e       cls,
  input  logic [FN_W-1:0] funct,
  output logic [AC_W-1:0] alu_ctl
);

  logic [AC_W-1:0] reg_code;

  always_comb begin
    case (funct)
      FN_AND:  reg_code = ALU_AND;
      FN_OR:   reg_code = ALU_OR;
      FN_ADD:  reg_code = ALU_ADD;
      FN_SUB:  reg_code = ALU_SUB;
      FN_SLT:  reg_code = ALU_SLT;
      default: reg_code = ALU_ADD;
    endcase
  end

  always_comb begin
    case (cls)
      CLS_BR:  alu_ctl = ALU_SUB;
      CLS_REG: alu_ctl = reg_code;
      default: alu_ctl = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
  import ctl_dec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  input  logic            zero,
  output logic            reg_dst,
  output logic            alu_src,
  output logic            mem_to_reg,
  output logic            reg_wr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            branch,
  output logic            pc_sel,
  output logic [AC_W-1:0] alu_ctl
);

  main_ctl_t       lvl1;
  logic [AC_W-1:0] lvl2_code;

  ctl_main_level u_main (
    .opcode (opcode),
    .ctl    (lvl1)
  );

  ctl_alu_level u_alu (
    .cls     (lvl1.cls),
    .funct   (funct),
    .alu_ctl (lvl2_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_dst    <= 1'b0;
      alu_src    <= 1'b0;
      mem_to_reg <= 1'b0;
      reg_wr     <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      branch     <= 1'b0;
      pc_sel     <= 1'b0;
      alu_ctl    <= '0;
    end else begin
      reg_dst    <= lvl1.reg_dst;
      alu_src    <= lvl1.alu_src;
      mem_to_reg <= lvl1.mem_to_reg;
      reg_wr     <= lvl1.reg_wr;
      mem_rd     <= lvl1.mem_rd;
      mem_wr     <= lvl1.mem_wr;
      branch     <= lvl1.branch;
      pc_sel     <= lvl1.branch & zero;
      alu_ctl    <= lvl2_code;
    end
  end

endmodule

// File: rtl/instr_ctrl_checker.sv
module instr_ctrl_checker
  import ctl_dec_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] opcode,
  input logic [FN_W-1:0] funct,
  input logic            zero,
  input logic            reg_dst,
  input logic            alu_src,
  input logic            mem_to_reg,
  input logic            reg_wr,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            branch,
  input logic            pc_sel,
  input logic [AC_W-1:0] alu_ctl
);

  function automatic logic fn_listed(logic [FN_W-1:0] f);
    return f == FN_ADD || f == FN_SUB || f == FN_AND || f == FN_OR || f == FN_SLT;
  endfunction

  function automatic logic op_listed(logic [OP_W-1:0] o);
    return o == OPC_REG || o == OPC_LOAD || o == OPC_STORE || o == OPC_BEQ;
  endfunction

  a_r3_reg_controls: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(opcode) == OPC_REG |->
      reg_dst && reg_wr && !alu_src && !mem_rd && !mem_wr && !branch);

  a_r4_bit2_from_funct: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(opcode) == OPC_REG && fn_listed($past(funct)) |->
      alu_ctl[2] == $past(funct[1]));

  a_r5_load_add: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(opcode) == OPC_LOAD |->
      alu_ctl == ALU_ADD && mem_rd && mem_to_reg && reg_wr && !mem_wr);

  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(opcode) == OPC_STORE |->
      mem_wr && !reg_wr && !mem_rd && alu_ctl == ALU_ADD);

  a_r7_beq_sub: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(opcode) == OPC_BEQ |->
      branch && alu_ctl == ALU_SUB && !reg_wr && !mem_wr);

  a_r8_pc_sel: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc_sel == ($past(opcode) == OPC_BEQ && $past(zero)));

  a_r9_unlisted_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !op_listed($past(opcode)) |->
      !reg_wr && !mem_rd && !mem_wr && !branch && alu_ctl == ALU_ADD);

  a_r2_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

bind instr_ctrl_decoder instr_ctrl_checker chk (
  .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .zero(zero),
  .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
  .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .branch(branch),
  .pc_sel(pc_sel), .alu_ctl(alu_ctl)
);

// File: tb/instr_ctrl_decoder_test.sv
module instr_ctrl_decoder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h00;
  logic       zero = 1'b0;
  logic       reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch, pc_sel;
  logic [3:0] alu_ctl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  instr_ctrl_decoder uut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .zero(zero),
    .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .branch(branch),
    .pc_sel(pc_sel), .alu_ctl(alu_ctl)
  );

  wire [11:0] outv = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr,
                      branch, pc_sel, alu_ctl};

  localparam int NVEC = 16;
  // {opcode, funct, zero, expected output vector}
  localparam logic [24:0] VECS [NVEC] = '{
    {6'h00, 6'h20, 1'b0, 12'h902},  // R3 R4 add
    {6'h00, 6'h22, 1'b0, 12'h906},  // R4 subtract
    {6'h00, 6'h24, 1'b1, 12'h900},  // R4 and, zero has no effect
    {6'h00, 6'h25, 1'b0, 12'h901},  // R4 or
    {6'h00, 6'h2A, 1'b0, 12'h907},  // R4 set-less-than
    {6'h23, 6'h00, 1'b0, 12'h782},  // R5 load
    {6'h23, 6'h22, 1'b1, 12'h782},  // R5 funct ignored
    {6'h2B, 6'h2A, 1'b0, 12'h442},  // R6 store
    {6'h2B, 6'h24, 1'b1, 12'h442},  // R6 funct ignored
    {6'h04, 6'h00, 1'b0, 12'h026},  // R7 R8 not taken
    {6'h04, 6'h00, 1'b1, 12'h036},  // R8 taken
    {6'h04, 6'h25, 1'b1, 12'h036},  // R7 funct ignored
    {6'h08, 6'h20, 1'b1, 12'h002},  // R9 unlisted
    {6'h3F, 6'h22, 1'b1, 12'h002},  // R9 unlisted
    {6'h02, 6'h2A, 1'b0, 12'h002},  // R9 unlisted
    {6'h00, 6'h2A, 1'b1, 12'h907}   // R4 back to register class
  };

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (outv !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, outv, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, inputs present a load
    opcode = 6'h23; funct = 6'h20; zero = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset clears", 12'h000);

    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      opcode = VECS[i][24:19];
      funct  = VECS[i][18:13];
      zero   = VECS[i][12];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d (R2-R9)", i), VECS[i][11:0]);
    end

    // R2: outputs hold between edges when inputs change
    opcode = 6'h2B; funct = 6'h00; zero = 1'b0;
    #1 check("R2 hold before edge", 12'h907);
    @(posedge clk); @(negedge clk);
    check("R2 update after edge", 12'h442);

    // R1: reset asserted mid-stream clears on next edge
    opcode = 6'h00; funct = 6'h20;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 reset mid-run", 12'h000);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 after reset release", 12'h902);

    // R8: taken branch followed by zero high on a non-branch
    opcode = 6'h04; zero = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 taken", 12'h036);
    opcode = 6'h23;
    @(posedge clk); @(negedge clk);
    check("R8 zero without branch", 12'h782);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule